// File: doc/BRIEF.md
# Debug Memory Service Controller

This block runs memory service commands on behalf of either the processor or an external debugger. Software loads a start address, a byte length and a data word into three operand registers that every command shares, then writes a command code into the control register. The only command here computes a CRC-32 over the range. The controller walks the range one 32-bit word at a time over a simple valid/ready read interface, folds each word into the running checksum and leaves the result in the data register. The operand registers are also the working registers. While the command runs, the address advances and the length counts down.

Two register ports lead into the same register file. The CPU-side port sees the registers at byte offsets 0x00 to 0xFF and is never restricted. The debug-side port sees the same registers mirrored across the window 0x100 to 0x1FFF. It can also reach them through offsets below 0x100, but only while the security input is low. While that input is high, such a low debug access is refused and recorded in a sticky error flag. A status register reports busy, done, a bus-error flag and that protection-error flag. A command written while another is still running is dropped without effect.

Top module: `memsvc_ctrl_top`

## Requirements
- R1: After reset every register reads zero. Registers sit at word offsets CTRL 0x00 (command in bits 1:0), STATUS 0x04 (bit0 done, bit1 busy, bit2 bus error, bit3 protection error), ADDR 0x08, LEN 0x0C and DATA 0x10. ADDR and LEN always read with bits 1:0 as zero.
- R2: The CPU port reaches the register at offset cpuAddr[7:2] whatever the security input is.
- R3: The debug port reaches the register at offset dbgAddr[7:2] for any address from 0x100 to 0x1FFF, and for addresses below 0x100 while security is low. Addresses of 0x2000 and above read zero, ignore writes and do not raise dbgErr.
- R4: While security is high, a debug access below 0x100 raises dbgErr in the same cycle, reads zero and is not written. It also sets STATUS bit3, which stays set until a 1 is written to STATUS bit3.
- R5: Writing CTRL with code 2'b01 while idle starts a CRC command. In the next cycle busy reads 1 and done and bus error read 0. Any other code starts nothing and leaves STATUS unchanged.
- R6: The CRC starts from DATA, folds each word in LSB first with the reflected polynomial 0xEDB88320 and no final inversion, and writes the result to DATA.
- R7: A command of N = LEN/4 words makes exactly N read handshakes at ADDR, ADDR+4, and so on. memAddr holds while a request waits. At the end ADDR reads start+4N, LEN reads 0 and done reads 1.
- R8: While busy, writes to CTRL, ADDR, LEN and DATA are dropped. The running command is neither restarted nor altered.
- R9: A read answered with memErr ends the command at once. It sets done and bus error, leaves ADDR at the faulting word and leaves DATA holding the CRC of the words before it.
- R10: A command started with LEN of 0 makes no memory request, sets done on the next cycle and leaves DATA unchanged.
- R11: When both ports write in the same cycle, the CPU write takes effect and the debug write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| secure | input | 1 | Device security bit; blocks low debug offsets |
| cpuSel | input | 1 | CPU port access strobe |
| cpuWe | input | 1 | CPU port write enable |
| cpuAddr | input | 8 | CPU port byte offset |
| cpuWdata | input | 32 | CPU port write data |
| cpuRdata | output | 32 | CPU port read data (same cycle) |
| dbgSel | input | 1 | Debug port access strobe |
| dbgWe | input | 1 | Debug port write enable |
| dbgAddr | input | 14 | Debug port byte offset |
| dbgWdata | input | 32 | Debug port write data |
| dbgRdata | output | 32 | Debug port read data (same cycle) |
| dbgErr | output | 1 | Debug access refused by security |
| memValid | output | 1 | Memory read request valid |
| memAddr | output | 32 | Memory read word address |
| memReady | input | 1 | Memory read accepted, data valid |
| memRdata | input | 32 | Memory read data |
| memErr | input | 1 | Memory read bus error |

## Verification
The bench restarts a command while one is in flight and writes new operands at the same time. A design that restarted would issue extra reads, clear done or end with a wrong checksum and address. It puts a bus error on a middle word. A design that kept going, or that folded the faulting word into the checksum, would show the wrong DATA, ADDR or status bits. It also covers a zero length, which a design would get wrong by issuing a read or hanging busy. Finally it drives secure debug accesses at both edges of the low range and beyond the window, and a same-cycle write from both ports. A design that got these wrong would write through a blocked access, miss the sticky flag or let the debug port win.

// File: rtl/memsvc_pkg.sv
package memsvc_pkg;

  localparam logic [5:0] IDX_CTRL = 6'd0;
  localparam logic [5:0] IDX_STAT = 6'd1;
  localparam logic [5:0] IDX_ADDR = 6'd2;
  localparam logic [5:0] IDX_LEN  = 6'd3;
  localparam logic [5:0] IDX_DATA = 6'd4;

  localparam logic [1:0]  CMD_CRC  = 2'b01;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // strobes from control to datapath
  typedef struct packed {
    logic        wrAddr;
    logic        wrLen;
    logic        wrData;
    logic [31:0] wdata;
    logic        step;
  } dpCtl_t;

  function automatic logic [31:0] crcFold(input logic [31:0] crcIn, input logic [31:0] word);
    logic [31:0] c;
    c = crcIn ^ word;
    for (int b = 0; b < 32; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/memsvc_datapath.sv
module memsvc_datapath
  import memsvc_pkg::*;
#(
  parameter int MEM_AW = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [31:0]       memRdata,
  output logic [MEM_AW-1:0] addrReg,
  output logic [LEN_W-1:0]  lenReg,
  output logic [31:0]       dataReg,
  output logic              lenZero,
  output logic              lastWord
);

  localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(4);
  localparam logic [MEM_AW-1:0] ADDR_STEP = MEM_AW'(4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      lenReg  <= '0;
      dataReg <= '0;
    end else if (ctl.step) begin
      addrReg <= addrReg + ADDR_STEP;
      lenReg  <= lenReg - LEN_STEP;
      dataReg <= crcFold(dataReg, memRdata);
    end else begin
      if (ctl.wrAddr) addrReg <= {ctl.wdata[MEM_AW-1:2], 2'b00};
      if (ctl.wrLen)  lenReg  <= {ctl.wdata[LEN_W-1:2], 2'b00};
      if (ctl.wrData) dataReg <= ctl.wdata;
    end
  end

  assign lenZero  = (lenReg == '0);
  assign lastWord = (lenReg == LEN_STEP);

  // R7
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> addrReg == $past(addrReg) + ADDR_STEP);

  // R7
  len_countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> lenReg == $past(lenReg) - LEN_STEP);

endmodule

// File: rtl/memsvc_ctrl.sv
module memsvc_ctrl
  import memsvc_pkg::*;
#(
  parameter int CPU_AW = 8,
  parameter int DBG_AW = 14,
  parameter int MEM_AW = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secure,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  input  logic              dbgSel,
  input  logic              dbgWe,
  input  logic [DBG_AW-1:0] dbgAddr,
  input  logic [31:0]       dbgWdata,
  output logic [31:0]       dbgRdata,
  output logic              dbgErr,
  output logic              memValid,
  input  logic              memReady,
  input  logic              memErr,
  input  logic [MEM_AW-1:0] addrReg,
  input  logic [LEN_W-1:0]  lenReg,
  input  logic [31:0]       dataReg,
  input  logic              lenZero,
  input  logic              lastWord,
  output dpCtl_t            dpCtl
);

  localparam logic [DBG_AW-1:0] DBG_LOW_END = DBG_AW'(32'h100);
  localparam logic [DBG_AW-1:0] DBG_WIN_END = DBG_AW'(32'h2000);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t state;
  logic   done, busErr, protErr, busy;

  logic       dbgLow, dbgInWin, dbgBlocked, dbgHit;
  logic       cpuWr, dbgWr, wrEn;
  logic [5:0] cpuIdx, dbgIdx, wrIdx;
  logic [31:0] wrVal;
  logic       start, accept;
  logic [31:0] statusWord;

  assign busy = (state == ST_RUN);

  // address decode for both ports
  assign cpuIdx     = cpuAddr[7:2];
  assign dbgIdx     = dbgAddr[7:2];
  assign dbgLow     = (dbgAddr < DBG_LOW_END);
  assign dbgInWin   = (dbgAddr < DBG_WIN_END);
  assign dbgBlocked = dbgSel && secure && dbgLow;
  assign dbgHit     = dbgSel && dbgInWin && !dbgBlocked;
  assign dbgErr     = dbgBlocked;

  // write arbitration: CPU first
  assign cpuWr = cpuSel && cpuWe;
  assign dbgWr = dbgHit && dbgWe && !cpuWr;
  assign wrEn  = cpuWr || dbgWr;
  assign wrIdx = cpuWr ? cpuIdx : dbgIdx;
  assign wrVal = cpuWr ? cpuWdata : dbgWdata;

  assign start  = wrEn && (wrIdx == IDX_CTRL) && (wrVal[1:0] == CMD_CRC) && !busy;
  assign accept = busy && memReady;

  assign statusWord = {28'd0, protErr, busErr, busy, done};

  function automatic logic [31:0] readReg(input logic [5:0] idx);
    case (idx)
      IDX_STAT: return statusWord;
      IDX_ADDR: return 32'(addrReg);
      IDX_LEN:  return 32'(lenReg);
      IDX_DATA: return dataReg;
      default:  return 32'd0;
    endcase
  endfunction

  always_comb begin
    cpuRdata = cpuSel ? readReg(cpuIdx) : 32'd0;
    dbgRdata = dbgHit ? readReg(dbgIdx) : 32'd0;
  end

  always_comb begin
    dpCtl        = '0;
    dpCtl.wdata  = wrVal;
    dpCtl.wrAddr = wrEn && !busy && (wrIdx == IDX_ADDR);
    dpCtl.wrLen  = wrEn && !busy && (wrIdx == IDX_LEN);
    dpCtl.wrData = wrEn && !busy && (wrIdx == IDX_DATA);
    dpCtl.step   = accept && !memErr;
  end

  assign memValid = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      busErr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            busErr <= 1'b0;
            if (lenZero) begin
              done <= 1'b1;
            end else begin
              done  <= 1'b0;
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (accept && memErr) begin
            busErr <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (accept && lastWord) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protErr <= 1'b0;
    end else if (dbgBlocked) begin
      protErr <= 1'b1;
    end else if (wrEn && (wrIdx == IDX_STAT) && wrVal[3]) begin
      protErr <= 1'b0;
    end
  end

  logic unusedBits;
  assign unusedBits = ^{cpuAddr[1:0], dbgAddr[1:0]};

  // R5
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !lenZero |=> busy && !done && !busErr);

  // R8
  busy_keeps_operands_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !memReady |=> busy && $stable(addrReg) && $stable(lenReg) && $stable(dataReg));

  // R4
  prot_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgBlocked |=> protErr);

  // R9
  buserr_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && memReady && memErr |=> done && busErr && !busy);

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && lenZero |=> done && !memValid);

endmodule

// File: rtl/memsvc_ctrl_top.sv
module memsvc_ctrl_top
  import memsvc_pkg::*;
#(
  parameter int CPU_AW = 8,
  parameter int DBG_AW = 14,
  parameter int MEM_AW = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secure,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  input  logic              dbgSel,
  input  logic              dbgWe,
  input  logic [DBG_AW-1:0] dbgAddr,
  input  logic [31:0]       dbgWdata,
  output logic [31:0]       dbgRdata,
  output logic              dbgErr,
  output logic              memValid,
  output logic [MEM_AW-1:0] memAddr,
  input  logic              memReady,
  input  logic [31:0]       memRdata,
  input  logic              memErr
);

  dpCtl_t            dpCtl;
  logic [MEM_AW-1:0] addrReg;
  logic [LEN_W-1:0]  lenReg;
  logic [31:0]       dataReg;
  logic              lenZero, lastWord;

  memsvc_ctrl #(.CPU_AW(CPU_AW), .DBG_AW(DBG_AW), .MEM_AW(MEM_AW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .secure(secure),
    .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .dbgSel(dbgSel), .dbgWe(dbgWe), .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata),
    .dbgErr(dbgErr),
    .memValid(memValid), .memReady(memReady), .memErr(memErr),
    .addrReg(addrReg), .lenReg(lenReg), .dataReg(dataReg),
    .lenZero(lenZero), .lastWord(lastWord), .dpCtl(dpCtl)
  );

  memsvc_datapath #(.MEM_AW(MEM_AW), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .memRdata(memRdata),
    .addrReg(addrReg), .lenReg(lenReg), .dataReg(dataReg),
    .lenZero(lenZero), .lastWord(lastWord)
  );

  assign memAddr = addrReg;

  // R7
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr));

endmodule

// File: tb/memsvc_ctrl_top_tb.sv
module memsvc_ctrl_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secure = 1'b0;
  logic        cpuSel = 1'b0, cpuWe = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        dbgSel = 1'b0, dbgWe = 1'b0;
  logic [13:0] dbgAddr = '0;
  logic [31:0] dbgWdata = '0;
  logic [31:0] dbgRdata;
  logic        dbgErr;
  logic        memValid;
  logic [31:0] memAddr;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memErr = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  int latency = 0;
  int waitCnt = 0;
  int reqCount = 0;
  int errIdx = -1;
  bit finished = 0;

  localparam logic [31:0] MEM_BASE = 32'h0000_1000;

  always #2 clk = ~clk;

  memsvc_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .secure(secure),
    .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .dbgSel(dbgSel), .dbgWe(dbgWe), .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata),
    .dbgErr(dbgErr), .memValid(memValid), .memAddr(memAddr), .memReady(memReady),
    .memRdata(memRdata), .memErr(memErr)
  );

  function automatic logic [31:0] memWord(input int idx);
    return (32'h9E3779B9 * 32'(idx + 1)) ^ 32'(idx << 8);
  endfunction

  function automatic logic [31:0] refCrc(input logic [31:0] init, input int first, input int n);
    logic [31:0] c;
    c = init;
    for (int w = first; w < first + n; w++) begin
      c = c ^ memWord(w);
      for (int b = 0; b < 32; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  // memory model with configurable latency
  always @(negedge clk) begin
    if (memReady) begin
      memReady = 1'b0;
      memErr   = 1'b0;
      waitCnt  = 0;
      reqCount++;
    end else if (memValid) begin
      if (waitCnt >= latency) begin
        int idx;
        idx = int'((memAddr - MEM_BASE) >> 2);
        memReady = 1'b1;
        memRdata = memWord(idx);
        memErr   = (idx == errIdx);
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuSel = 1; cpuWe = 1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuSel = 0; cpuWe = 0;
  endtask

  task automatic cpuRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuSel = 1; cpuWe = 0; cpuAddr = a;
    #1 d = cpuRdata;
    cpuSel = 0;
  endtask

  task automatic dbgWrite(input logic [13:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    dbgSel = 1; dbgWe = 1; dbgAddr = a; dbgWdata = d;
    #1 err = dbgErr;
    @(negedge clk);
    dbgSel = 0; dbgWe = 0;
  endtask

  task automatic dbgRead(input logic [13:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    dbgSel = 1; dbgWe = 0; dbgAddr = a;
    #1 d = dbgRdata; err = dbgErr;
    dbgSel = 0;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      cpuRead(8'h04, s);
      if (s[0]) return;
    end
    nChecks++; nFail++;
    $display("FAIL R7: done never set, actual 0 expected 1");
  endtask

  task automatic setupCrc(input int first, input int words, input logic [31:0] init);
    cpuWrite(8'h08, MEM_BASE + 32'(first * 4));
    cpuWrite(8'h0C, 32'(words * 4));
    cpuWrite(8'h10, init);
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      cpuRead(8'(i * 4), d);
      chk("R1 reset value", d, 32'd0);
    end
  endtask

  task automatic testRegs();
    logic [31:0] d;
    cpuWrite(8'h0C, 32'h13);
    cpuRead(8'h0C, d); chk("R1 LEN low bits", d, 32'h10);
    cpuWrite(8'h08, 32'h1003);
    cpuRead(8'h08, d); chk("R1 ADDR low bits", d, 32'h1000);
    cpuWrite(8'h10, 32'hCAFE0001);
    cpuRead(8'h10, d); chk("R1 DATA readback", d, 32'hCAFE0001);
  endtask

  task automatic testCrcBasic();
    logic [31:0] d;
    latency = 0; errIdx = -1;
    setupCrc(0, 4, 32'hFFFFFFFF);
    reqCount = 0;
    cpuWrite(8'h00, 32'h1);
    cpuRead(8'h04, d); chk("R5 busy after start", d[1:0], 2'b10);
    waitDone();
    cpuRead(8'h10, d); chk("R6 CRC 4 words", d, refCrc(32'hFFFFFFFF, 0, 4));
    cpuRead(8'h08, d); chk("R7 end ADDR", d, MEM_BASE + 32'd16);
    cpuRead(8'h0C, d); chk("R7 end LEN", d, 32'd0);
    cpuRead(8'h04, d); chk("R7 status done", d, 32'h1);
    chk("R7 request count", 32'(reqCount), 32'd4);
  endtask

  task automatic testDebugStart();
    logic [31:0] d; logic e;
    latency = 3; errIdx = -1;
    dbgWrite(14'h108, MEM_BASE + 32'd40, e);
    dbgWrite(14'h10C, 32'd4, e);
    dbgWrite(14'h110, 32'd0, e);
    reqCount = 0;
    dbgWrite(14'h100, 32'h1, e);
    chk("R3 debug window no error", 32'(e), 32'd0);
    waitDone();
    dbgRead(14'h1F10, d, e); chk("R3 mirrored DATA", d, refCrc(32'd0, 10, 1));
    dbgRead(14'h008, d, e);  chk("R3 low debug unsecured", d, MEM_BASE + 32'd44);
    chk("R7 one request", 32'(reqCount), 32'd1);
  endtask

  task automatic testBusyDrop();
    logic [31:0] d;
    latency = 5; errIdx = -1;
    setupCrc(2, 8, 32'h12345678);
    reqCount = 0;
    cpuWrite(8'h00, 32'h1);
    cpuWrite(8'h08, 32'h0000_2000);
    cpuWrite(8'h10, 32'hDEADBEEF);
    cpuWrite(8'h0C, 32'd64);
    cpuWrite(8'h00, 32'h1);
    cpuRead(8'h04, d); chk("R8 still busy not done", d[1:0], 2'b10);
    waitDone();
    cpuRead(8'h10, d); chk("R8 CRC unaltered", d, refCrc(32'h12345678, 2, 8));
    cpuRead(8'h08, d); chk("R8 ADDR unaltered", d, MEM_BASE + 32'd40);
    chk("R8 no restart requests", 32'(reqCount), 32'd8);
  endtask

  task automatic testBusErr();
    logic [31:0] d;
    latency = 1; errIdx = 7;
    setupCrc(5, 5, 32'hFFFFFFFF);
    reqCount = 0;
    cpuWrite(8'h00, 32'h1);
    waitDone();
    cpuRead(8'h04, d); chk("R9 done and bus error", d, 32'h5);
    cpuRead(8'h08, d); chk("R9 ADDR at fault", d, MEM_BASE + 32'd28);
    cpuRead(8'h10, d); chk("R9 partial CRC", d, refCrc(32'hFFFFFFFF, 5, 2));
    chk("R9 stopped early", 32'(reqCount), 32'd3);
    errIdx = -1;
  endtask

  task automatic testZeroLen();
    logic [31:0] d;
    cpuWrite(8'h0C, 32'd0);
    cpuWrite(8'h10, 32'h55AA55AA);
    reqCount = 0;
    cpuWrite(8'h00, 32'h1);
    cpuRead(8'h04, d); chk("R10 done, bus error cleared (R5)", d, 32'h1);
    cpuRead(8'h10, d); chk("R10 DATA unchanged", d, 32'h55AA55AA);
    chk("R10 no request", 32'(reqCount) + 32'(memValid), 32'd0);
  endtask

  task automatic testBadCmd();
    logic [31:0] d;
    cpuWrite(8'h0C, 32'd8);
    cpuWrite(8'h00, 32'h2);
    cpuRead(8'h04, d); chk("R5 bad code no start", d, 32'h1);
    chk("R5 bad code no request", 32'(memValid), 32'd0);
  endtask

  task automatic testSecure();
    logic [31:0] d; logic e;
    cpuWrite(8'h08, 32'h0000_3000);
    secure = 1;
    dbgRead(14'h004, d, e);
    chk("R4 blocked read error", 32'(e), 32'd1);
    chk("R4 blocked read zero", d, 32'd0);
    dbgWrite(14'h0FC, 32'd0, e);
    dbgWrite(14'h008, 32'h0000_4000, e);
    chk("R4 blocked write error", 32'(e), 32'd1);
    cpuRead(8'h08, d); chk("R4 blocked write ignored / R2 CPU works", d, 32'h0000_3000);
    cpuRead(8'h04, d); chk("R4 sticky flag", d[3], 1'b1);
    dbgRead(14'h108, d, e); chk("R3 secure upper window", d, 32'h0000_3000);
    chk("R3 upper window no error", 32'(e), 32'd0);
    dbgWrite(14'h2008, 32'h0000_5000, e);
    chk("R3 beyond window no error", 32'(e), 32'd0);
    dbgRead(14'h2008, d, e); chk("R3 beyond window reads zero", d, 32'd0);
    cpuRead(8'h08, d); chk("R3 beyond window write ignored", d, 32'h0000_3000);
    cpuRead(8'h04, d); chk("R4 flag still set", d[3], 1'b1);
    cpuWrite(8'h04, 32'h8);
    cpuRead(8'h04, d); chk("R4 write-one clears", d[3], 1'b0);
    secure = 0;
  endtask

  task automatic testDualWrite();
    logic [31:0] d;
    @(negedge clk);
    cpuSel = 1; cpuWe = 1; cpuAddr = 8'h08; cpuWdata = 32'h0000_6000;
    dbgSel = 1; dbgWe = 1; dbgAddr = 14'h10C; dbgWdata = 32'd24;
    @(negedge clk);
    cpuSel = 0; cpuWe = 0; dbgSel = 0; dbgWe = 0;
    cpuRead(8'h08, d); chk("R11 CPU write wins", d, 32'h0000_6000);
    cpuRead(8'h0C, d); chk("R11 debug write dropped", d, 32'd8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testRegs();
    testCrcBasic();
    testDebugStart();
    testBusyDrop();
    testBusErr();
    testZeroLen();
    testBadCmd();
    testSecure();
    testDualWrite();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule